// File: doc/BRIEF.md
# Internal Data Space Router

This block sits between a CPU core and its on-chip data storage. It takes one read request and one write request per cycle. Each request has an 8-bit address and a flag that says whether the instruction used direct or indirect addressing. The block sends each request either to its own 256-byte scratch RAM or to an external special-function-register bank. It returns read data one cycle after a read is accepted.

The lower half of the address space, 00H to 7FH, is plain RAM for both addressing modes. The upper half, 80H to FFH, holds two separate things at the same addresses. Direct accesses there go to the register bank. Indirect accesses there, including stack pushes and pops, go to a second, physically separate 128-byte RAM area. The register bank drives a hit flag for each side to say whether the decoded register exists. A read of an absent register returns 00H. A write to an absent register is never passed on.

Top module: `idata_space_router`

## Requirements
- R1: The RAM stores 256 bytes at indices 00H to FFH. A byte written at any index is returned by a later read that routes to that same index.
- R2: Addresses whose bit 7 is 0 (00H to 7FH) select RAM for both direct and indirect requests. Such a request never asserts `sfr_rd_sel` or `sfr_we`, and direct and indirect requests reach the same byte.
- R3: A direct request with address bit 7 set goes to the register port. A read asserts `sfr_rd_sel` with `sfr_raddr` equal to the address and returns `sfr_rdata`. A write drives `sfr_waddr` and `sfr_wdata` and leaves the RAM unchanged.
- R4: An indirect request with address bit 7 set goes to the upper RAM and never to the register port. Its data stays separate from the register at the same address.
- R5: A sequence of indirect writes at rising upper addresses, read back in reverse order as a stack would, returns each byte that was stored.
- R6: A direct read whose register is absent (`sfr_rd_hit` low) returns 00H. A direct write whose register is absent (`sfr_wr_hit` low) keeps `sfr_we` low.
- R7: `rd_valid` rises exactly one cycle after a cycle with `rd_en` high. `rd_data` is 00H whenever `rd_valid` is low, and writes alone never raise `rd_valid`.
- R8: A read and a write to the same RAM index in the same cycle return the old byte. The new byte is returned by the next read.
- R9: Synchronous active-high reset clears `rd_valid` and `rd_data` on the next clock edge. RAM contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request valid |
| rd_indirect | input | 1 | Read uses indirect addressing |
| rd_addr | input | 8 | Read address |
| wr_en | input | 1 | Write request valid |
| wr_indirect | input | 1 | Write uses indirect addressing |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data |
| sfr_rd_sel | output | 1 | Read is routed to the register bank |
| sfr_raddr | output | 8 | Register bank read address |
| sfr_rdata | input | 8 | Register bank read data (combinational on `sfr_raddr`) |
| sfr_rd_hit | input | 1 | Register at `sfr_raddr` exists |
| sfr_we | output | 1 | Register bank write strobe |
| sfr_waddr | output | 8 | Register bank write address |
| sfr_wdata | output | 8 | Register bank write data |
| sfr_wr_hit | input | 1 | Register at `sfr_waddr` exists |

## Verification
Assertions check the routing rules on every cycle: a low-half or indirect request never reaches the register port, a direct upper request always does, no strobe goes out to an absent register, `rd_valid` keeps its one-cycle timing, and an absent register reads as zero. Some behaviours can only be shown by the bench's scenarios, because they depend on stored data. These are that upper RAM and the registers at the same address hold separate values, that stack-ordered readback works, that a same-cycle read and write returns the old byte, and that every RAM index keeps its value.

// File: rtl/idata_space_pkg.sv
package idata_space_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;

    // Where a request lands after decoding
    typedef enum logic [1:0] {
        SPACE_NONE     = 2'd0,
        SPACE_RAM_LOW  = 2'd1,
        SPACE_RAM_HIGH = 2'd2,
        SPACE_SFR      = 2'd3
    } space_e;

    // One access request from the core
    typedef struct packed {
        logic              en;
        logic              indirect;
        logic [ADDR_W-1:0] addr;
    } acc_t;

    // Upper half is overlaid: mode decides between registers and upper RAM
    function automatic space_e classify(input logic en, input logic indirect,
                                        input logic upper_half);
        if (!en)
            return SPACE_NONE;
        else if (!upper_half)
            return SPACE_RAM_LOW;
        else if (indirect)
            return SPACE_RAM_HIGH;
        else
            return SPACE_SFR;
    endfunction

    function automatic logic is_ram(input space_e s);
        return (s == SPACE_RAM_LOW) || (s == SPACE_RAM_HIGH);
    endfunction

endpackage

// File: rtl/idata_space_decode.sv
module idata_space_decode
    import idata_space_pkg::*;
(
    input  acc_t   req,
    output space_e space
);
    localparam int TOP_BIT = ADDR_W - 1;

    always_comb begin
        space = classify(req.en, req.indirect, req.addr[TOP_BIT]);
    end

endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Contents are deliberately not reset
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read; same-index write in this cycle is not yet visible
    always_ff @(posedge clk) begin
        if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/idata_read_return.sv
module idata_read_return
    import idata_space_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  space_e        rd_space,
    input  logic [DW-1:0] sfr_rdata,
    input  logic          sfr_hit,
    input  logic [DW-1:0] ram_q,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    space_e        src_q;
    logic [DW-1:0] sfr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SPACE_NONE;
            sfr_q <= '0;
        end else begin
            src_q <= rd_space;
            if (rd_space == SPACE_SFR)
                sfr_q <= sfr_hit ? sfr_rdata : '0;
        end
    end

    always_comb begin
        rd_valid = (src_q != SPACE_NONE);
        unique case (src_q)
            SPACE_SFR:      rd_data = sfr_q;
            SPACE_RAM_LOW,
            SPACE_RAM_HIGH: rd_data = ram_q;
            default:        rd_data = '0;
        endcase
    end

    AST_SFR_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_space == SPACE_SFR && !sfr_hit) |=> (rd_data == '0)) // R6
        else $error("absent register read not zero");

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)) // R7
        else $error("rd_data nonzero while idle");

endmodule

// File: rtl/idata_space_router.sv
module idata_space_router
    import idata_space_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_indirect,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic              wr_indirect,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_rd_sel,
    output logic [ADDR_W-1:0] sfr_raddr,
    input  logic [DATA_W-1:0] sfr_rdata,
    input  logic              sfr_rd_hit,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_waddr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic              sfr_wr_hit
);
    acc_t              rd_req, wr_req;
    space_e            rd_space, wr_space;
    logic [DATA_W-1:0] ram_q;
    logic              ram_re, ram_we;

    assign rd_req = '{en: rd_en, indirect: rd_indirect, addr: rd_addr};
    assign wr_req = '{en: wr_en, indirect: wr_indirect, addr: wr_addr};

    idata_space_decode u_rd_dec (.req(rd_req), .space(rd_space));
    idata_space_decode u_wr_dec (.req(wr_req), .space(wr_space));

    assign ram_re = is_ram(rd_space);
    assign ram_we = is_ram(wr_space);

    idata_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .re    (ram_re),
        .raddr (rd_addr),
        .we    (ram_we),
        .waddr (wr_addr),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    // Register-bank side
    assign sfr_rd_sel = (rd_space == SPACE_SFR);
    assign sfr_raddr  = rd_addr;
    assign sfr_we     = (wr_space == SPACE_SFR) && sfr_wr_hit;
    assign sfr_waddr  = wr_addr;
    assign sfr_wdata  = wr_data;

    idata_read_return #(.DW(DATA_W)) u_ret (
        .clk       (clk),
        .rst       (rst),
        .rd_space  (rd_space),
        .sfr_rdata (sfr_rdata),
        .sfr_hit   (sfr_rd_hit),
        .ram_q     (ram_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    AST_LOW_NOT_SFR: assert property (@(posedge clk) disable iff (rst)
        ((rd_en && !rd_addr[ADDR_W-1]) |-> !sfr_rd_sel) and
        ((wr_en && !wr_addr[ADDR_W-1]) |-> !sfr_we)) // R2
        else $error("low address reached register port");

    AST_DIRECT_UPPER_SFR: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_indirect && rd_addr[ADDR_W-1]) |-> sfr_rd_sel) // R3
        else $error("direct upper read missed register port");

    AST_INDIRECT_NOT_SFR: assert property (@(posedge clk) disable iff (rst)
        ((rd_en && rd_indirect) |-> !sfr_rd_sel) and
        ((wr_en && wr_indirect) |-> !sfr_we)) // R4
        else $error("indirect access reached register port");

    AST_NO_WRITE_ABSENT: assert property (@(posedge clk) disable iff (rst)
        sfr_we |-> (sfr_wr_hit && wr_en)) // R6
        else $error("write strobe to absent register");

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid == $past(rd_en)) // R7
        else $error("rd_valid timing wrong");

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!rd_valid && rd_data == '0)) // R9
        else $error("reset did not clear read return");

endmodule

// File: tb/test_idata_space_router.sv
module test_idata_space_router;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_en = 0, rd_indirect = 0, wr_en = 0, wr_indirect = 0;
    logic [7:0] rd_addr = 0, wr_addr = 0, wr_data = 0;
    logic       rd_valid, sfr_rd_sel, sfr_we, sfr_rd_hit, sfr_wr_hit;
    logic [7:0] rd_data, sfr_raddr, sfr_rdata, sfr_waddr, sfr_wdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    idata_space_router i_idata_space_router (.*);

    // Register bank model: present where low nibble is 0, plus 81H
    logic [7:0] bank [256];
    function automatic logic present(input logic [7:0] a);
        return a[7] && (a[3:0] == 4'h0 || a == 8'h81);
    endfunction
    assign sfr_rd_hit = present(sfr_raddr);
    assign sfr_wr_hit = present(sfr_waddr);
    assign sfr_rdata  = bank[sfr_raddr];
    always @(posedge clk) if (sfr_we) bank[sfr_waddr] <= sfr_wdata;

    // Reference RAM and scoreboard
    logic [7:0] ref_ram [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, 0);
            else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
        end else if (!rst) begin
            chk(rd_data == 8'h00, "R7 idle data", rd_data, 0);
        end
    end

    // One cycle with an optional read and an optional write
    task automatic step(input bit re, input bit ri, input logic [7:0] ra,
                        input bit we, input bit wi, input logic [7:0] wa,
                        input logic [7:0] wd, input string tag);
        @(negedge clk);
        rd_en = re; rd_indirect = ri; rd_addr = ra;
        wr_en = we; wr_indirect = wi; wr_addr = wa; wr_data = wd;
        #1;
        if (re) begin
            automatic logic [7:0] e;
            if (!ra[7] || ri) e = ref_ram[ra];
            else e = present(ra) ? bank[ra] : 8'h00;
            exp_q.push_back(e);
            tag_q.push_back(tag);
            chk(sfr_rd_sel == (ra[7] && !ri), "R2/R3/R4 read routing", sfr_rd_sel, ra[7] && !ri);
        end
        if (we) begin
            automatic bit to_sfr = wa[7] && !wi;
            chk(sfr_we == (to_sfr && present(wa)), "R3/R4/R6 write strobe", sfr_we, to_sfr && present(wa));
            if (to_sfr) chk(sfr_waddr == wa && sfr_wdata == wd, "R3 write port", sfr_wdata, wd);
            else ref_ram[wa] = wd;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0;
    endtask

    initial begin
        #1_000_000;
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin bank[i] = 8'h5A ^ i[7:0]; ref_ram[i] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!rd_valid && rd_data == 0, "R9 reset state", rd_data, 0);
        rst = 0;
        // R1: fill every index indirectly, read back
        for (int i = 0; i < 256; i++) step(0, 0, 0, 1, 1, i[7:0], 8'hC3 ^ i[7:0], "R1");
        for (int i = 0; i < 256; i++) step(1, 1, i[7:0], 0, 0, 0, 0, "R1 readback");
        // R2: low half same byte in both modes
        step(0, 0, 0, 1, 0, 8'h12, 8'hA1, "R2");
        step(1, 1, 8'h12, 0, 0, 0, 0, "R2 indirect sees direct write");
        step(1, 0, 8'h7F, 0, 0, 0, 0, "R2 direct low read");
        // R3/R4: overlay separation at A0H
        step(0, 0, 0, 1, 0, 8'hA0, 8'h3C, "R3");
        step(0, 0, 0, 1, 1, 8'hA0, 8'hE7, "R4");
        step(1, 0, 8'hA0, 0, 0, 0, 0, "R3 direct reads register");
        step(1, 1, 8'hA0, 0, 0, 0, 0, "R4 indirect reads upper RAM");
        step(1, 0, 8'h81, 0, 0, 0, 0, "R3 register 81H");
        // R6: absent registers
        step(0, 0, 0, 1, 0, 8'h85, 8'hFF, "R6 write absent");
        step(1, 0, 8'h85, 0, 0, 0, 0, "R6 read absent returns 00");
        step(1, 1, 8'h85, 0, 0, 0, 0, "R6 upper RAM untouched");
        // R5: stack push/pop in upper RAM
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, 8'hF8 + i[7:0], 8'h10 + i[7:0], "R5 push");
        for (int i = 5; i >= 0; i--) step(1, 1, 8'hF8 + i[7:0], 0, 0, 0, 0, "R5 pop");
        // R8: same-cycle read and write
        step(1, 1, 8'h40, 1, 1, 8'h40, 8'h99, "R8 old data");
        step(1, 0, 8'h40, 0, 0, 0, 0, "R8 new data");
        step(1, 1, 8'hC0, 1, 1, 8'hC0, 8'h77, "R8 upper old data");
        step(1, 1, 8'hC0, 0, 0, 0, 0, "R8 upper new data");
        // R7: write-only cycles do not raise rd_valid (monitor flags it)
        step(0, 0, 0, 1, 1, 8'h20, 8'h01, "R7");
        idle();
        @(negedge clk);
        chk(!rd_valid, "R7 no valid after write", rd_valid, 0);
        // R9: reset mid-stream
        step(1, 1, 8'h20, 0, 0, 0, 0, "R9 before reset");
        idle();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(!rd_valid && rd_data == 0, "R9 cleared", rd_data, 0);
        rst = 0;
        step(1, 1, 8'h20, 0, 0, 0, 0, "R9 RAM kept over reset");
        idle();
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule